// File: doc/BRIEF.md
# Environment-Configuration Access Gate

This block sits in front of two environment-configuration registers of a hart: the supervisor-level one and the hypervisor-level one. The hypervisor register also has a high-half alias. For each request the gate decides whether the access may go ahead. It returns one of three results in the same cycle: no exception, illegal-instruction, or virtual-instruction fault. The decision uses the current privilege mode, the virtualization flag, whether supervisor mode is implemented, the state-enable extension switch, and the environment-config enable bit taken from the machine, hypervisor and supervisor state-enable levels.

The gate also holds both configuration registers. When an access is allowed, a write updates only the writable fields, and which fields are writable depends on the register and on the core width. When an access faults, it changes nothing and reads back zero.

A fourth request kind covers supervisor timecompare access from a virtualized context. For this kind the gate checks the hypervisor counter-enable time bit together with the timecompare-enable field held in the hypervisor register.

Top module: `envcfg_gate`

## Requirements
- R1: Result code encoding: 0 means no exception, 1 means illegal-instruction, 2 means virtual-instruction fault. Privilege encoding: 0 is user, 1 is supervisor, 3 is machine. For the three configuration selects (0 supervisor register, 1 hypervisor register, 2 hypervisor high half), the result is 0 in machine mode or when the extension switch is off.
- R2: Otherwise, a clear machine-level enable bit gives result 1. This check comes before every other check.
- R3: Otherwise, when virtualized, a clear hypervisor-level enable bit gives result 2.
- R4: Otherwise, when virtualized in user mode, a clear supervisor-level enable bit gives result 2.
- R5: Otherwise, in non-virtualized user mode on a hart that implements supervisor mode, a clear supervisor-level enable bit gives result 1. Every other case gives 0.
- R6: A request that faults does not change either register, and its read data is zero. When no request is valid, the result is 0 and the read data is 0.
- R7: An allowed write to the supervisor register updates only bit 0 (I/O fence ordering), bits 5:4 (cache-block invalidate), bit 6 (cache-block clean/flush) and bit 7 (cache-block zero). All other bits read zero.
- R8: An allowed full write to the hypervisor register updates the same four fields. When the 64-bit flag is set, it also updates bit 62 (page memory types) and bit 63 (timecompare enable). When the flag is clear, bits 63:62 keep their value.
- R9: An allowed high-half write takes write data bits 31:30 into register bits 63:62 and leaves bits 31:0 unchanged. A high-half read returns register bits 63:32 in the low half, zero-extended.
- R10: Select 3 (timecompare): when virtualized and not in machine mode, the result is 2 unless both the hypervisor counter time bit and hypervisor register bit 63 are set. In all other cases it is 0. This request never writes and reads zero.
- R11: After reset both registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| privMode | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virtOn | input | 1 | Hart runs virtualized |
| hasSMode | input | 1 | Supervisor mode is implemented |
| extOn | input | 1 | State-enable extension switch |
| mEnBit | input | 1 | Machine-level env-config enable bit |
| hEnBit | input | 1 | Hypervisor-level env-config enable bit |
| sEnBit | input | 1 | Supervisor-level env-config enable bit |
| hCntTm | input | 1 | Hypervisor counter-enable time bit |
| is64 | input | 1 | Core is 64 bits wide |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | Request is a write |
| reqSel | input | 2 | Target: 0 supervisor reg, 1 hypervisor reg, 2 hypervisor high half, 3 timecompare |
| wrData | input | 64 | Write data |
| excCode | output | 2 | Exception result, same cycle |
| rdData | output | 64 | Read data, zero on fault |

## Verification
The permission result is swept over every combination of privilege, virtualization, supervisor presence, extension switch and the three enable bits. Each point is checked against an ordered model, which shows whether the machine-level check really takes precedence and whether virtualized user mode is kept apart from plain user mode. Write masks are tested with all-ones and all-zeros patterns, with the 64-bit flag both set and clear, and through the high-half alias. This shows which bits each path can reach and which it must preserve. The timecompare sweep covers all four combinations of the counter bit and the register bit, so a rule that needs only one of them to be set is caught.

// File: rtl/envcfg_gate_pkg.sv
package envcfg_gate_pkg;
  localparam int CFG_W  = 64;
  localparam int HALF_W = CFG_W / 2;

  // field positions
  localparam int FIOM_POS  = 0;
  localparam int CBIE_LO   = 4;
  localparam int CBIE_HI   = 5;
  localparam int CBCFE_POS = 6;
  localparam int CBZE_POS  = 7;
  localparam int PBMTE_POS = 62;
  localparam int STCE_POS  = 63;

  localparam logic [CFG_W-1:0] ONE = {{(CFG_W-1){1'b0}}, 1'b1};
  localparam logic [CFG_W-1:0] COMMON_MASK =
      (ONE << FIOM_POS) | (ONE << CBIE_LO) | (ONE << CBIE_HI) |
      (ONE << CBCFE_POS) | (ONE << CBZE_POS);
  localparam logic [CFG_W-1:0] HI_MASK = (ONE << PBMTE_POS) | (ONE << STCE_POS);
  localparam logic [CFG_W-1:0] WIDE_MASK = COMMON_MASK | HI_MASK;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_ILL  = 2'd1,
    EXC_VIRT = 2'd2
  } excE;

  typedef enum logic [1:0] {
    SEL_SCFG  = 2'd0,
    SEL_HCFG  = 2'd1,
    SEL_HHI   = 2'd2,
    SEL_TCMP  = 2'd3
  } selE;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef struct packed {
    logic wrS;
    logic wrH;
    logic wrHHi;
    logic rdS;
    logic rdH;
    logic rdHHi;
  } strobeT;
endpackage

// File: rtl/envcfg_gate_ctrl.sv
module envcfg_gate_ctrl
  import envcfg_gate_pkg::*;
(
  input  logic [1:0] privMode,
  input  logic       virtOn,
  input  logic       hasSMode,
  input  logic       extOn,
  input  logic       mEnBit,
  input  logic       hEnBit,
  input  logic       sEnBit,
  input  logic       hCntTm,
  input  logic       stceBit,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqSel,
  output excE        excCode,
  output strobeT     strobes
);
  logic isM, isU;
  excE  cfgExc, tcmpExc, selExc;
  logic granted;

  assign isM = (privMode == PRIV_M);
  assign isU = (privMode == PRIV_U);

  // ordered state-enable check
  always_comb begin
    if (isM || !extOn)                      cfgExc = EXC_NONE;
    else if (!mEnBit)                       cfgExc = EXC_ILL;
    else if (virtOn && !hEnBit)             cfgExc = EXC_VIRT;
    else if (virtOn && isU && !sEnBit)      cfgExc = EXC_VIRT;
    else if (isU && hasSMode && !sEnBit)    cfgExc = EXC_ILL;
    else                                    cfgExc = EXC_NONE;
  end

  // timecompare: both bits needed, logical conjunction
  always_comb begin
    if (!isM && virtOn && !(hCntTm && stceBit)) tcmpExc = EXC_VIRT;
    else                                        tcmpExc = EXC_NONE;
  end

  always_comb begin
    if (!reqValid)                    selExc = EXC_NONE;
    else if (reqSel == SEL_TCMP)      selExc = tcmpExc;
    else                              selExc = cfgExc;
  end

  assign excCode = selExc;
  assign granted = reqValid && (selExc == EXC_NONE);

  always_comb begin
    strobes       = '0;
    strobes.wrS   = granted &&  reqWrite && (reqSel == SEL_SCFG);
    strobes.wrH   = granted &&  reqWrite && (reqSel == SEL_HCFG);
    strobes.wrHHi = granted &&  reqWrite && (reqSel == SEL_HHI);
    strobes.rdS   = granted && !reqWrite && (reqSel == SEL_SCFG);
    strobes.rdH   = granted && !reqWrite && (reqSel == SEL_HCFG);
    strobes.rdHHi = granted && !reqWrite && (reqSel == SEL_HHI);
  end
endmodule

// File: rtl/envcfg_gate_dp.sv
module envcfg_gate_dp
  import envcfg_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             is64,
  input  strobeT           strobes,
  input  logic [CFG_W-1:0] wrData,
  output logic [CFG_W-1:0] rdData,
  output logic             stceBit
);
  logic [CFG_W-1:0] sCfg, hCfg;
  logic [CFG_W-1:0] hMask, hiVal;

  assign hMask = is64 ? WIDE_MASK : COMMON_MASK;
  assign hiVal = {wrData[HALF_W-1:0], hCfg[HALF_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sCfg <= '0;
      hCfg <= '0;
    end else begin
      if (strobes.wrS)
        sCfg <= (sCfg & ~COMMON_MASK) | (wrData & COMMON_MASK);
      if (strobes.wrH)
        hCfg <= (hCfg & ~hMask) | (wrData & hMask);
      else if (strobes.wrHHi)
        hCfg <= (hCfg & ~HI_MASK) | (hiVal & HI_MASK);
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdS)   rdData = sCfg;
    if (strobes.rdH)   rdData = hCfg;
    if (strobes.rdHHi) rdData = {{HALF_W{1'b0}}, hCfg[CFG_W-1:HALF_W]};
  end

  assign stceBit = hCfg[STCE_POS];

  AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrHHi |=> $stable(hCfg[HALF_W-1:0])); // R9
  AST_NARROW_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrH && !is64) |=> $stable(hCfg[CFG_W-1:PBMTE_POS])); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrS || strobes.wrH || strobes.wrHHi) |=> ($stable(sCfg) && $stable(hCfg))); // R6
endmodule

// File: rtl/envcfg_gate.sv
module envcfg_gate
  import envcfg_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  privMode,
  input  logic        virtOn,
  input  logic        hasSMode,
  input  logic        extOn,
  input  logic        mEnBit,
  input  logic        hEnBit,
  input  logic        sEnBit,
  input  logic        hCntTm,
  input  logic        is64,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqSel,
  input  logic [63:0] wrData,
  output logic [1:0]  excCode,
  output logic [63:0] rdData
);
  strobeT strobes;
  excE    excInt;
  logic   stceBit;

  envcfg_gate_ctrl u_ctrl (
    .privMode(privMode), .virtOn(virtOn), .hasSMode(hasSMode), .extOn(extOn),
    .mEnBit(mEnBit), .hEnBit(hEnBit), .sEnBit(sEnBit), .hCntTm(hCntTm),
    .stceBit(stceBit), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSel(reqSel), .excCode(excInt), .strobes(strobes)
  );

  envcfg_gate_dp u_dp (
    .clk(clk), .rstN(rstN), .is64(is64), .strobes(strobes),
    .wrData(wrData), .rdData(rdData), .stceBit(stceBit)
  );

  assign excCode = excInt;

  AST_MACHINE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (privMode == PRIV_M) |-> (excCode == EXC_NONE)); // R1
  AST_MEN_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSel != SEL_TCMP && extOn && privMode != PRIV_M && !mEnBit)
      |-> (excCode == EXC_ILL)); // R2
  AST_HEN_VIRT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSel != SEL_TCMP && extOn && privMode != PRIV_M && mEnBit &&
     virtOn && !hEnBit) |-> (excCode == EXC_VIRT)); // R3
  AST_FAULT_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (excCode != EXC_NONE) |-> (rdData == '0)); // R6
  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (excCode == EXC_NONE && rdData == '0)); // R6
endmodule

// File: tb/test_envcfg_gate.sv
`timescale 1ns/1ps
module test_envcfg_gate;
  logic clk = 1'b0;
  logic rstN;
  logic [1:0] privMode;
  logic virtOn, hasSMode, extOn, mEnBit, hEnBit, sEnBit, hCntTm, is64;
  logic reqValid, reqWrite;
  logic [1:0] reqSel;
  logic [63:0] wrData;
  logic [1:0] excCode;
  logic [63:0] rdData;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  envcfg_gate i_envcfg_gate (
    .clk(clk), .rstN(rstN), .privMode(privMode), .virtOn(virtOn),
    .hasSMode(hasSMode), .extOn(extOn), .mEnBit(mEnBit), .hEnBit(hEnBit),
    .sEnBit(sEnBit), .hCntTm(hCntTm), .is64(is64), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqSel(reqSel), .wrData(wrData),
    .excCode(excCode), .rdData(rdData)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int expPerm(int p, bit v, bit hs, bit e, bit m, bit h, bit s);
    if (p == 3 || !e) return 0;       // R1
    if (!m) return 1;                  // R2
    if (v && !h) return 2;             // R3
    if (v && p == 0 && !s) return 2;   // R4
    if (p == 0 && hs && !s) return 1;  // R5
    return 0;
  endfunction

  // machine-mode access (always allowed)
  task automatic mAcc(input logic [1:0] sel, input bit wr, input logic [63:0] d);
    @(negedge clk);
    privMode = 2'd3; virtOn = 0; reqValid = 1; reqWrite = wr; reqSel = sel; wrData = d;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic mRead(input logic [1:0] sel, output logic [63:0] v);
    @(negedge clk);
    privMode = 2'd3; virtOn = 0; reqValid = 1; reqWrite = 0; reqSel = sel;
    #2 v = rdData;
    reqValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    rstN = 0; privMode = 0; virtOn = 0; hasSMode = 1; extOn = 1;
    mEnBit = 1; hEnBit = 1; sEnBit = 1; hCntTm = 0; is64 = 1;
    reqValid = 0; reqWrite = 0; reqSel = 0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R11 reset values, R6 idle
    #2 chk("R6 idle exc", {62'b0, excCode}, 64'd0);
    chk("R6 idle rd", rdData, 64'd0);
    mRead(2'd0, v); chk("R11 sCfg reset", v, 64'd0);
    mRead(2'd1, v); chk("R11 hCfg reset", v, 64'd0);

    // R7 supervisor write mask
    mAcc(2'd0, 1, '1);
    mRead(2'd0, v); chk("R7 sCfg ones", v, 64'h0000_0000_0000_00F1);
    // R8 hypervisor full write, 64-bit
    mAcc(2'd1, 1, '1);
    mRead(2'd1, v); chk("R8 hCfg ones 64", v, 64'hC000_0000_0000_00F1);
    is64 = 0;
    mAcc(2'd1, 1, '0);
    mRead(2'd1, v); chk("R8 hCfg zero narrow keeps top", v, 64'hC000_0000_0000_0000);
    // R9 high half
    mRead(2'd2, v); chk("R9 high read", v, 64'h0000_0000_C000_0000);
    mAcc(2'd1, 1, '1);
    mAcc(2'd2, 1, 64'hFFFF_FFFF_0000_0000);
    mRead(2'd1, v); chk("R9 high write zero keeps low", v, 64'h0000_0000_0000_00F1);
    mAcc(2'd2, 1, 64'h0000_0000_8000_0000);
    mRead(2'd1, v); chk("R9 high write bit31", v, 64'h8000_0000_0000_00F1);
    is64 = 1;

    // R6 faulting write leaves state
    @(negedge clk);
    privMode = 0; virtOn = 0; extOn = 1; mEnBit = 0;
    reqValid = 1; reqWrite = 1; reqSel = 0; wrData = '0;
    #2 chk("R2 fault exc", {62'b0, excCode}, 64'd1);
    @(negedge clk); reqSel = 1; reqWrite = 1;
    @(negedge clk); reqValid = 0; mEnBit = 1;
    mRead(2'd0, v); chk("R6 sCfg unchanged", v, 64'h0000_0000_0000_00F1);
    mRead(2'd1, v); chk("R6 hCfg unchanged", v, 64'h8000_0000_0000_00F1);

    // R1-R5 exhaustive sweep (reads; rdData shows sCfg when allowed)
    for (int p = 0; p < 4; p++) begin
      if (p == 2) continue;
      for (int c = 0; c < 64; c++) begin
        int e;
        @(negedge clk);
        privMode = p[1:0]; virtOn = c[0]; hasSMode = c[1]; extOn = c[2];
        mEnBit = c[3]; hEnBit = c[4]; sEnBit = c[5];
        reqValid = 1; reqWrite = 0; reqSel = 0;
        e = expPerm(p, c[0], c[1], c[2], c[3], c[4], c[5]);
        #2;
        chk($sformatf("R1 R2 R3 R4 R5 perm p=%0d c=%0d", p, c), {62'b0, excCode}, 64'(e));
        chk($sformatf("R6 rd p=%0d c=%0d", p, c), rdData, (e == 0) ? 64'hF1 : 64'h0);
      end
    end
    @(negedge clk); reqValid = 0;
    hasSMode = 1; extOn = 1; mEnBit = 1; hEnBit = 1; sEnBit = 1;

    // R10 timecompare: hCfg bit63 currently 1
    for (int k = 0; k < 4; k++) begin
      mAcc(2'd2, 1, {32'b0, k[1], 31'b0});
      @(negedge clk);
      privMode = 1; virtOn = 1; hCntTm = k[0];
      reqValid = 1; reqWrite = 0; reqSel = 3;
      #2 chk($sformatf("R10 virt k=%0d", k), {62'b0, excCode}, (k == 3) ? 64'd0 : 64'd2);
      chk("R10 rd zero", rdData, 64'd0);
      virtOn = 0;
      #2 chk($sformatf("R10 nonvirt k=%0d", k), {62'b0, excCode}, 64'd0);
      virtOn = 1; privMode = 3;
      #2 chk($sformatf("R10 machine k=%0d", k), {62'b0, excCode}, 64'd0);
      reqValid = 0; virtOn = 0;
    end

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule